// File: doc/BRIEF.md
# Streaming SHA-2 Message Padder

This block sits between a byte-oriented message source and a SHA-2 schedule and round engine. It accepts a message as a stream of narrow big-endian words and emits padded message words one per accepted cycle. Each message word passes straight through a single output register, so no block is ever buffered. When the final input word arrives, the block adds the padding itself: a single 1 bit, then zero words, then the big-endian bit length in the last words of a block. If the length field has no room left in the current block, it emits an extra block that holds only padding.

A mode input picks the block format for each message: 512-bit blocks with a 64-bit length field, or 1024-bit blocks with a 128-bit length field. With the default 16-bit word, a block is 32 output words in the narrow mode and 64 in the wide mode. Both sides use valid/ready handshakes. The output marks the first word of every block and the closing word of the last block.

Top module: `sha2_stream_padder`

## Requirements
- R1: After reset, outValid is low and inReady is high.
- R2: Message words come out unchanged, in order, one output word per input word, with the first byte in the most significant position.
- R3: At the first accepted word of a message, modeWide=0 selects 512-bit blocks (32 words of 16 bits) and modeWide=1 selects 1024-bit blocks (64 words). The mode input is ignored from then until the message's final word has been emitted.
- R4: On a word with inLast=1, inBytes (0 to DATA_W/8) gives the count of valid leading bytes. The next byte becomes 8'h80 and any bytes after it become zero. Whatever the ignored bytes held has no effect. inBytes=0 marks an empty final word, which is how an empty message is sent.
- R5: When the final word has all bytes valid, the next output word is a lone 1 in its most significant bit (16'h8000).
- R6: Between the pad bit and the length field, every output word is zero.
- R7: The last 64/DATA_W words (narrow mode) or 128/DATA_W words (wide mode) of the final block carry the message length in bits, most significant word first. In wide mode the upper 64 bits of this field are zero.
- R8: If the pad byte or pad word lands past the start of the length field region, the block zero-fills to the end of that block and emits one more block that ends with the length.
- R9: outFirst is high exactly on word 0 of each block.
- R10: outFinal is high only on the last word of the final block of a message.
- R11: While outValid is high and outReady is low, outData and the flags hold still. No word is lost or duplicated. inReady stays low while padding words are emitted.
- R12: A reset in the middle of a message discards the partial message, and the next message is padded from a clean state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Padder accepts the input word this cycle |
| inData | input | DATA_W | Message word, first byte in the top bits |
| inLast | input | 1 | Word is the final one of the message |
| inBytes | input | clog2(DATA_W/8+1) | Valid leading bytes of the final word |
| modeWide | input | 1 | 0: 512-bit blocks, 1: 1024-bit blocks |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer takes the output word |
| outData | output | DATA_W | Padded message word |
| outFirst | output | 1 | Word 0 of a block |
| outFinal | output | 1 | Last word of the last block of a message |

## Verification
A word counter that drifts would move outFirst off the block boundary within one block. It would also shift the length words off the block end, or cut them short, before the message's outFinal appears. A sequencer stuck in a wrong phase shows within a few words: a missing or doubled 8'h80, nonzero fill, or a length word in the wrong slot. A stall that drops or repeats data changes the count of words between outFirst pulses and breaks the exact byte match on the next handshake. The stimulus puts message ends on both sides of the length-field boundary, in both modes, under several backpressure patterns.

// File: rtl/sha2pad_pkg.sv
package sha2pad_pkg;

  typedef enum logic [1:0] {
    SEL_MSG  = 2'd0,
    SEL_PAD  = 2'd1,
    SEL_ZERO = 2'd2,
    SEL_LEN  = 2'd3
  } wordSel_e;

  typedef enum logic [1:0] {
    ST_PASS   = 2'd0,
    ST_PADBIT = 2'd1,
    ST_ZERO   = 2'd2,
    ST_LEN    = 2'd3
  } padState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;       // capture a new output word
    logic       clear;      // first word of a message: restart bit count
    wordSel_e   sel;        // source of the output word
    logic       partial;    // final message word with fewer bytes than a full word
    logic [2:0] keepBytes;  // valid leading bytes of a partial word
    logic [3:0] lenLeft;    // length word index, 0 = least significant
    logic       first;      // word 0 of a block
    logic       final_;     // closing word of the final block
  } padCtl_t;

endpackage

// File: rtl/sha2pad_ctrl.sv
module sha2pad_ctrl
  import sha2pad_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int BYTES = DATA_W / 8,
  localparam int CNT_W = $clog2(BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inLast,
  input  logic [CNT_W-1:0] inBytes,
  input  logic             modeWide,
  input  logic             canLoad,
  output logic             inReady,
  output padCtl_t          ctl
);

  localparam int WPB_N  = 512 / DATA_W;
  localparam int WPB_W  = 1024 / DATA_W;
  localparam int LENW_N = 64 / DATA_W;
  localparam int LENW_W = 128 / DATA_W;
  localparam int IDX_W  = $clog2(WPB_W);
  localparam int LI_W   = $clog2(LENW_W);

  localparam logic [IDX_W-1:0] LASTN = IDX_W'(WPB_N - 1);
  localparam logic [IDX_W-1:0] LASTW = IDX_W'(WPB_W - 1);
  localparam logic [IDX_W-1:0] THRN  = IDX_W'(WPB_N - LENW_N);
  localparam logic [IDX_W-1:0] THRW  = IDX_W'(WPB_W - LENW_W);
  localparam logic [LI_W-1:0]  LTOPN = LI_W'(LENW_N - 1);
  localparam logic [LI_W-1:0]  LTOPW = LI_W'(LENW_W - 1);

  padState_e        state, stNext;
  logic [IDX_W-1:0] idx;
  logic [LI_W-1:0]  lenLeft;
  logic             startOfMsg;
  logic             modeQ;

  logic             wideEff;
  logic [IDX_W-1:0] lastIdx, thr, idxNext;
  logic [LI_W-1:0]  lenTop;
  logic             lastPartial;
  padState_e        afterPad;

  assign wideEff     = startOfMsg ? modeWide : modeQ;
  assign lastIdx     = wideEff ? LASTW : LASTN;
  assign thr         = wideEff ? THRW : THRN;
  assign lenTop      = wideEff ? LTOPW : LTOPN;
  assign idxNext     = (idx == lastIdx) ? '0 : idx + 1'b1;
  assign lastPartial = inLast && (inBytes < CNT_W'(BYTES));
  assign afterPad    = (idxNext == thr) ? ST_LEN : ST_ZERO;

  always_comb begin
    ctl           = '0;
    ctl.sel       = SEL_MSG;
    ctl.first     = (idx == '0);
    ctl.keepBytes = 3'(inBytes);
    ctl.lenLeft   = 4'(lenLeft);
    inReady       = 1'b0;
    stNext        = state;
    unique case (state)
      ST_PASS: begin
        inReady = canLoad;
        if (inValid && canLoad) begin
          ctl.load    = 1'b1;
          ctl.sel     = SEL_MSG;
          ctl.clear   = startOfMsg;
          ctl.partial = lastPartial;
          if (inLast) stNext = lastPartial ? afterPad : ST_PADBIT;
        end
      end
      ST_PADBIT: begin
        if (canLoad) begin
          ctl.load = 1'b1;
          ctl.sel  = SEL_PAD;
          stNext   = afterPad;
        end
      end
      ST_ZERO: begin
        if (canLoad) begin
          ctl.load = 1'b1;
          ctl.sel  = SEL_ZERO;
          if (idxNext == thr) stNext = ST_LEN;
        end
      end
      ST_LEN: begin
        if (canLoad) begin
          ctl.load   = 1'b1;
          ctl.sel    = SEL_LEN;
          ctl.final_ = (lenLeft == '0);
          if (lenLeft == '0) stNext = ST_PASS;
        end
      end
      default: stNext = ST_PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_PASS;
      idx        <= '0;
      lenLeft    <= '0;
      startOfMsg <= 1'b1;
      modeQ      <= 1'b0;
    end else if (ctl.load) begin
      state <= stNext;
      idx   <= idxNext;
      if (state == ST_PASS && startOfMsg) begin
        modeQ      <= modeWide;
        startOfMsg <= 1'b0;
      end
      if (state != ST_LEN && stNext == ST_LEN) lenLeft <= lenTop;
      else if (state == ST_LEN) lenLeft <= lenLeft - 1'b1;
      if (state == ST_LEN && lenLeft == '0) startOfMsg <= 1'b1;
    end
  end

  // R7
  len_align_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_LEN |-> idx >= thr);

  // R10
  block_end_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.final_ |-> idx == lastIdx);

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx <= lastIdx);

  // R11
  no_take_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_PASS) |=> !(inReady && $past(state) == ST_LEN && $past(lenLeft) != '0));

endmodule

// File: rtl/sha2pad_data.sv
module sha2pad_data
  import sha2pad_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  padCtl_t           ctl,
  input  logic [DATA_W-1:0] inData,
  input  logic              outReady,
  output logic              canLoad,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outFirst,
  output logic              outFinal
);

  localparam int BYTES = DATA_W / 8;

  logic [63:0]       bitCount, countBase, countAdd;
  logic [63:0]       lenShift;
  logic [DATA_W-1:0] msgWord, nextWord;
  int                shAmt;

  assign canLoad = !outValid || outReady;

  // mask the final partial word and drop the pad byte behind its data
  always_comb begin
    msgWord = inData;
    if (ctl.partial) begin
      for (int k = 0; k < BYTES; k++) begin
        if (k < int'(ctl.keepBytes))
          msgWord[DATA_W-1-8*k -: 8] = inData[DATA_W-1-8*k -: 8];
        else if (k == int'(ctl.keepBytes))
          msgWord[DATA_W-1-8*k -: 8] = 8'h80;
        else
          msgWord[DATA_W-1-8*k -: 8] = 8'h00;
      end
    end
  end

  always_comb begin
    shAmt    = int'(ctl.lenLeft) * DATA_W;
    lenShift = bitCount >> shAmt;
    unique case (ctl.sel)
      SEL_MSG:  nextWord = msgWord;
      SEL_PAD:  nextWord = {1'b1, {(DATA_W-1){1'b0}}};
      SEL_ZERO: nextWord = '0;
      SEL_LEN:  nextWord = lenShift[DATA_W-1:0];
      default:  nextWord = '0;
    endcase
  end

  assign countBase = ctl.clear ? 64'd0 : bitCount;
  assign countAdd  = ctl.partial ? (64'(ctl.keepBytes) << 3) : 64'(DATA_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCount <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outFirst <= 1'b0;
      outFinal <= 1'b0;
    end else begin
      if (ctl.load && ctl.sel == SEL_MSG) bitCount <= countBase + countAdd;
      if (ctl.load) begin
        outValid <= 1'b1;
        outData  <= nextWord;
        outFirst <= ctl.first;
        outFinal <= ctl.final_;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

  // R11
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outFinal) && $stable(outFirst));

  // R10
  final_not_first_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && outFinal |-> !outFirst);

endmodule

// File: rtl/sha2_stream_padder.sv
module sha2_stream_padder
  import sha2pad_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int BYTES = DATA_W / 8,
  localparam int CNT_W = $clog2(BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  input  logic [CNT_W-1:0]  inBytes,
  input  logic              modeWide,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outFirst,
  output logic              outFinal
);

  padCtl_t ctl;
  logic    canLoad;

  sha2pad_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inLast   (inLast),
    .inBytes  (inBytes),
    .modeWide (modeWide),
    .canLoad  (canLoad),
    .inReady  (inReady),
    .ctl      (ctl)
  );

  sha2pad_data #(.DATA_W(DATA_W)) i_data (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .inData   (inData),
    .outReady (outReady),
    .canLoad  (canLoad),
    .outValid (outValid),
    .outData  (outData),
    .outFirst (outFirst),
    .outFinal (outFinal)
  );

endmodule

// File: tb/test_sha2_stream_padder.sv
module test_sha2_stream_padder;

  localparam int DATA_W = 16;
  localparam int BYTES  = DATA_W / 8;
  localparam int CNT_W  = $clog2(BYTES + 1);

  // stimulus table: message length in bytes, wide mode, stall pattern, flip mode mid-message
  localparam int NV = 10;
  localparam int vecLen   [NV] = '{0, 3, 55, 56, 62, 64, 111, 112, 200, 5};
  localparam int vecWide  [NV] = '{0, 0, 0,  0,  0,  0,  1,   1,   1,   1};
  localparam int vecStall [NV] = '{0, 1, 2,  3,  0,  2,  1,   3,   2,   0};
  localparam int vecFlip  [NV] = '{0, 0, 0,  0,  0,  1,  0,   0,   1,   0};

  logic              clk = 1'b0;
  logic              rst;
  logic              inValid, inReady, inLast, modeWide;
  logic [DATA_W-1:0] inData;
  logic [CNT_W-1:0]  inBytes;
  logic              outValid, outReady, outFirst, outFinal;
  logic [DATA_W-1:0] outData;

  int testsRun = 0;
  int testsFail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sha2_stream_padder #(.DATA_W(DATA_W)) i_sha2_stream_padder (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .inBytes(inBytes), .modeWide(modeWide), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outFirst(outFirst), .outFinal(outFinal)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      testsRun++;
      testsFail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  function automatic logic [7:0] msgByte(int j);
    return 8'((j * 37 + 5) ^ (j >> 3));
  endfunction

  function automatic int padTotal(int len, bit wide);
    int blk = wide ? 128 : 64;
    int lb  = wide ? 16 : 8;
    return ((len + 1 + lb + blk - 1) / blk) * blk;
  endfunction

  function automatic logic [7:0] expByte(int len, bit wide, int j);
    int lb = wide ? 16 : 8;
    int total = padTotal(len, wide);
    int pos;
    logic [63:0] bits;
    if (j < len) return msgByte(j);
    if (j == len) return 8'h80;
    if (j >= total - lb) begin
      pos  = total - 1 - j;
      bits = 64'(len) * 64'd8;
      if (pos < 8) return 8'(bits >> (8 * pos));
      return 8'h00;
    end
    return 8'h00;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runMsg(int len, bit wide, int stall, bit flip);
    int nIn = (len == 0) ? 1 : (len + BYTES - 1) / BYTES;
    int lastBytes = len - (nIn - 1) * BYTES;
    int wpb = wide ? 1024 / DATA_W : 512 / DATA_W;
    int nOut = padTotal(len, wide) / BYTES;
    int inPtr = 0, outPtr = 0, cyc = 0;
    int dataErr = 0, flagErr = 0, extra = 0, stallTake = 0;
    logic [DATA_W-1:0] firstBad = '0, firstExp = '0;
    logic [DATA_W-1:0] expW;
    bit gap;
    while (outPtr < nOut && cyc < 5000) begin
      @(negedge clk);
      gap = (stall == 2) && (cyc % 4 == 1);
      if (inPtr < nIn && !gap) begin
        inValid = 1'b1;
        for (int k = 0; k < BYTES; k++) begin
          int j = inPtr * BYTES + k;
          inData[DATA_W-1-8*k -: 8] = (j < len) ? msgByte(j) : 8'hA5;
        end
        inLast  = (inPtr == nIn - 1);
        inBytes = inLast ? CNT_W'(lastBytes) : CNT_W'(BYTES);
      end else begin
        inValid = 1'b0;
        inData  = '0;
        inLast  = 1'b0;
        inBytes = '0;
      end
      modeWide = (flip && inPtr > 0) ? !wide : wide;
      case (stall)
        1: outReady = (cyc % 3) != 2;
        2: outReady = (cyc % 5) != 0;
        3: outReady = (cyc % 7) < 2;
        default: outReady = 1'b1;
      endcase
      #2;
      if (inValid && inReady) begin
        if (inPtr >= nIn) stallTake++;
        inPtr++;
      end
      if (inReady && inPtr >= nIn && !inValid && outValid && outPtr < nOut - 1 && outPtr >= nIn) stallTake += 0;
      if (outValid && outReady) begin
        for (int k = 0; k < BYTES; k++)
          expW[DATA_W-1-8*k -: 8] = expByte(len, wide, outPtr * BYTES + k);
        if (outData !== expW && dataErr == 0) begin
          firstBad = outData;
          firstExp = expW;
        end
        if (outData !== expW) dataErr++;
        if (outFirst !== ((outPtr % wpb) == 0)) flagErr++;
        if (outFinal !== (outPtr == nOut - 1)) flagErr++;
        outPtr++;
      end
      cyc++;
    end
    // drain: no further words may appear
    inValid  = 1'b0;
    inLast   = 1'b0;
    outReady = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #2;
      if (outValid) extra++;
    end
    check(dataErr == 0, "R2 R4 R5 R6 R7 R8", $sformatf("len %0d wide %0d word data", len, wide),
          firstBad, firstExp);
    check(flagErr == 0, "R9 R10", $sformatf("len %0d flag errors", len), flagErr, 0);
    check(outPtr == nOut && extra == 0 && inPtr == nIn, "R11",
          $sformatf("len %0d words out (+extra)", len), outPtr + extra, nOut);
    if (flip)
      check(outPtr == nOut && dataErr == 0, "R3", "mode change mid-message ignored", outPtr, nOut);
  endtask

  initial begin
    rst = 1'b1;
    inValid = 1'b0; inData = '0; inLast = 1'b0; inBytes = '0;
    modeWide = 1'b0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    // R1
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    check(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);

    for (int v = 0; v < NV; v++)
      runMsg(vecLen[v], vecWide[v] != 0, vecStall[v], vecFlip[v] != 0);

    // R12: abort a message mid-stream by reset
    @(negedge clk);
    modeWide = 1'b1;
    inValid  = 1'b1;
    inData   = 16'hDEAD;
    inLast   = 1'b0;
    inBytes  = CNT_W'(BYTES);
    outReady = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    #2;
    check(outValid == 1'b0, "R12", "outValid after mid-message reset", outValid, 0);
    runMsg(7, 1'b0, 1, 1'b0);
    // R3: narrow then wide back to back with a short message
    runMsg(1, 1'b1, 0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule